// File: doc/BRIEF.md
# NAND Flash Address Cycle Latch

This block is the receive side of a small-page NAND flash interface. It watches an 8-bit input bus together with a chip enable, a command-latch enable, an address-latch enable and a write strobe. From these it separates command bytes from address bytes. It assembles a byte column, a half-page select and a 15-bit page (row) address from a three-cycle address sequence.

The half-page select is never sent on the bus as an address bit. It is set by the read-pointer command that came before the address: code 00h selects the first 256-byte half and code 01h selects the second. When the third address byte arrives, the block raises a one-cycle completion pulse. It flags the address as illegal when the top bit of that byte is set. It also loads a byte pointer into the 528-byte page register, and each read strobe then moves that pointer forward by one. The write strobe is a synchronous one-cycle pulse that marks the rising edge of the write enable.

Top module: `nand_addr_latch`

## Requirements
- R1: After reset, colAddr, rowAddr, halfSel, bytePtr, addrDone and addrIllegal are all zero.
- R2: A byte is a command when weStrobe is high, ceN is low, cle is high and ale is low. Code 00h clears halfSel, code 01h sets it, and any other code leaves halfSel unchanged.
- R3: The first address byte after a command or reset is copied to colAddr on the clock edge where it is taken. An address byte is one with weStrobe high, ceN low, ale high and cle low.
- R4: The second address byte goes to rowAddr[7:0]. Bits 6..0 of the third address byte go to rowAddr[14:8].
- R5: Address bytes after the third change neither colAddr nor rowAddr, and they raise no addrDone.
- R6: addrDone is high for exactly one cycle, the cycle after the edge that takes the third address byte.
- R7: addrIllegal takes bit 7 of the third address byte, and it is cleared by the next command.
- R8: Any command returns the address cycle count to zero, so the next address byte is treated as a first byte again.
- R9: When the third address byte is taken, bytePtr is loaded with {halfSel, colAddr}. Each later cycle with rdStrobe high and ceN low adds one to bytePtr, and the count stops at 527.
- R10: Bytes taken while ceN is high, or while cle and ale are both high, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ceN | input | 1 | Active-low chip enable |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| weStrobe | input | 1 | One-cycle pulse at the write-enable rising edge |
| ioIn | input | 8 | Input data bus |
| rdStrobe | input | 1 | One-cycle read strobe that advances the pointer |
| colAddr | output | 8 | Column byte offset within the half page |
| halfSel | output | 1 | Half-page select bit |
| rowAddr | output | 15 | Page (row) address |
| bytePtr | output | 10 | Page register byte pointer |
| addrDone | output | 1 | Address-complete pulse |
| addrIllegal | output | 1 | Third byte had bit 7 set |

## Verification
The bench builds the block with its default values: an 8-bit bus, a 528-byte page and three address cycles. With these values the pointer ceiling of 527 is only a few reads away from the largest loaded pointer, 511. It is also within reach of random read bursts. With a fixed seed, the random mix of commands, address bytes, surplus cycles, disabled-chip bytes and conflicting-enable bytes reaches every state of the cycle counter, and so exercises both the saturation of the counter and its return to zero on a command.

// File: rtl/nal_pkg.sv
package nal_pkg;
  typedef struct packed {
    logic setHalf;
    logic clrHalf;
    logic clrIllegal;
    logic latchCol;
    logic latchRowLo;
    logic latchRowHi;
    logic incPtr;
  } ctlStrobe_t;
endpackage

// File: rtl/nal_control.sv
module nal_control #(
  parameter int DATA_W = 8,
  parameter int ADDR_CYCLES = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic ceN,
  input  logic cle,
  input  logic ale,
  input  logic weStrobe,
  input  logic rdStrobe,
  input  logic [DATA_W-1:0] ioIn,
  output nal_pkg::ctlStrobe_t strobes
);
  localparam int CNT_W = $clog2(ADDR_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(ADDR_CYCLES);

  logic [CNT_W-1:0] cycleCnt;
  logic cmdTake;
  logic addrTake;

  assign cmdTake  = weStrobe && !ceN && cle && !ale;
  assign addrTake = weStrobe && !ceN && ale && !cle;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cycleCnt <= '0;
    end else if (cmdTake) begin
      cycleCnt <= '0;
    end else if (addrTake && cycleCnt != CNT_FULL) begin
      cycleCnt <= cycleCnt + 1'b1;
    end
  end

  always_comb begin
    strobes = '0;
    strobes.setHalf    = cmdTake && (ioIn == DATA_W'(1));
    strobes.clrHalf    = cmdTake && (ioIn == '0);
    strobes.clrIllegal = cmdTake;
    strobes.latchCol   = addrTake && (cycleCnt == CNT_W'(0));
    strobes.latchRowLo = addrTake && (cycleCnt == CNT_W'(1));
    strobes.latchRowHi = addrTake && (cycleCnt == CNT_W'(2));
    strobes.incPtr     = rdStrobe && !ceN;
  end
endmodule

// File: rtl/nal_datapath.sv
module nal_datapath #(
  parameter int DATA_W = 8,
  parameter int PAGE_BYTES = 528
) (
  input  logic clk,
  input  logic rstN,
  input  nal_pkg::ctlStrobe_t strobes,
  input  logic [DATA_W-1:0] ioIn,
  output logic [DATA_W-1:0] colAddr,
  output logic halfSel,
  output logic [2*DATA_W-2:0] rowAddr,
  output logic [$clog2(PAGE_BYTES)-1:0] bytePtr,
  output logic addrDone,
  output logic addrIllegal
);
  localparam int PTR_W = $clog2(PAGE_BYTES);
  localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(PAGE_BYTES - 1);

  logic [DATA_W-1:0] rowLo;
  logic [DATA_W-2:0] rowHi;

  assign rowAddr = {rowHi, rowLo};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colAddr     <= '0;
      rowLo       <= '0;
      rowHi       <= '0;
      halfSel     <= 1'b0;
      addrDone    <= 1'b0;
      addrIllegal <= 1'b0;
      bytePtr     <= '0;
    end else begin
      addrDone <= strobes.latchRowHi;
      if (strobes.setHalf) halfSel <= 1'b1;
      else if (strobes.clrHalf) halfSel <= 1'b0;
      if (strobes.latchCol) colAddr <= ioIn;
      if (strobes.latchRowLo) rowLo <= ioIn;
      if (strobes.latchRowHi) rowHi <= ioIn[DATA_W-2:0];
      if (strobes.clrIllegal) addrIllegal <= 1'b0;
      else if (strobes.latchRowHi) addrIllegal <= ioIn[DATA_W-1];
      if (strobes.latchRowHi) begin
        bytePtr <= PTR_W'({halfSel, colAddr});
      end else if (strobes.incPtr && bytePtr != PTR_MAX) begin
        bytePtr <= bytePtr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/nand_addr_latch.sv
module nand_addr_latch #(
  parameter int DATA_W = 8,
  parameter int PAGE_BYTES = 528,
  parameter int ADDR_CYCLES = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic ceN,
  input  logic cle,
  input  logic ale,
  input  logic weStrobe,
  input  logic [DATA_W-1:0] ioIn,
  input  logic rdStrobe,
  output logic [DATA_W-1:0] colAddr,
  output logic halfSel,
  output logic [2*DATA_W-2:0] rowAddr,
  output logic [$clog2(PAGE_BYTES)-1:0] bytePtr,
  output logic addrDone,
  output logic addrIllegal
);
  nal_pkg::ctlStrobe_t strobes;

  nal_control #(.DATA_W(DATA_W), .ADDR_CYCLES(ADDR_CYCLES)) u_ctl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .cle(cle), .ale(ale),
    .weStrobe(weStrobe), .rdStrobe(rdStrobe), .ioIn(ioIn), .strobes(strobes)
  );

  nal_datapath #(.DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .ioIn(ioIn),
    .colAddr(colAddr), .halfSel(halfSel), .rowAddr(rowAddr),
    .bytePtr(bytePtr), .addrDone(addrDone), .addrIllegal(addrIllegal)
  );
endmodule

// File: rtl/nal_checker.sv
module nal_checker #(
  parameter int DATA_W = 8,
  parameter int PAGE_BYTES = 528
) (
  input logic clk,
  input logic rstN,
  input logic ceN,
  input logic cle,
  input logic ale,
  input logic weStrobe,
  input logic rdStrobe,
  input logic [DATA_W-1:0] colAddr,
  input logic halfSel,
  input logic [2*DATA_W-2:0] rowAddr,
  input logic [$clog2(PAGE_BYTES)-1:0] bytePtr,
  input logic addrDone,
  input logic addrIllegal
);
  localparam int PTR_W = $clog2(PAGE_BYTES);
  logic cmdIn, addrIn;
  assign cmdIn  = weStrobe && !ceN && cle && !ale;
  assign addrIn = weStrobe && !ceN && ale && !cle;

  // R6: a completion pulse needs an address byte one edge earlier
  a_r6_done_after_addr: assert property (@(posedge clk) disable iff (!rstN)
    addrDone |-> $past(addrIn));
  // R6: the pulse lasts one cycle
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rstN)
    addrDone |=> !addrDone);
  // R9: the pointer never passes the last byte of the page
  a_r9_ptr_bound: assert property (@(posedge clk) disable iff (!rstN)
    bytePtr <= PTR_W'(PAGE_BYTES - 1));
  // R9: the pointer is loaded from half select and column
  a_r9_ptr_load: assert property (@(posedge clk) disable iff (!rstN)
    addrDone |-> bytePtr == PTR_W'({halfSel, colAddr}));
  // R5, R10: the address holds when no address byte was taken
  a_r5_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    !addrIn |=> $stable(rowAddr) && $stable(colAddr));
  // R2: the half select moves only on a command
  a_r2_half_cmd: assert property (@(posedge clk) disable iff (!rstN)
    !cmdIn |=> $stable(halfSel));
  // R7: the illegal flag is cleared by a command
  a_r7_clear: assert property (@(posedge clk) disable iff (!rstN)
    cmdIn |=> !addrIllegal);
endmodule

bind nand_addr_latch nal_checker #(.DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)) u_chk (
  .clk(clk), .rstN(rstN), .ceN(ceN), .cle(cle), .ale(ale),
  .weStrobe(weStrobe), .rdStrobe(rdStrobe), .colAddr(colAddr),
  .halfSel(halfSel), .rowAddr(rowAddr), .bytePtr(bytePtr),
  .addrDone(addrDone), .addrIllegal(addrIllegal)
);

// File: tb/tb_nand_addr_latch.sv
module tb_nand_addr_latch;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b1, cle = 1'b0, ale = 1'b0, weStrobe = 1'b0, rdStrobe = 1'b0;
  logic [7:0] ioIn = '0;
  logic [7:0] colAddr;
  logic halfSel;
  logic [14:0] rowAddr;
  logic [9:0] bytePtr;
  logic addrDone, addrIllegal;

  int checks = 0;
  int errors = 0;
  bit doneFlag = 0;

  logic [7:0] mCol;
  logic [14:0] mRow;
  logic mHalf, mIll, mDone;
  logic [9:0] mPtr;
  int mCnt;

  always #2.5 clk = ~clk;

  nand_addr_latch dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chkAll(input string req);
    chk({req, " col"}, 32'(colAddr), 32'(mCol));
    chk({req, " row"}, 32'(rowAddr), 32'(mRow));
    chk({req, " half"}, 32'(halfSel), 32'(mHalf));
    chk({req, " ptr"}, 32'(bytePtr), 32'(mPtr));
    chk({req, " done"}, 32'(addrDone), 32'(mDone));
    chk({req, " illegal"}, 32'(addrIllegal), 32'(mIll));
  endtask

  // one bus cycle: drive at negedge, let one posedge pass, return at negedge
  task automatic busCycle(input logic c, input logic a, input logic e, input logic rd,
                          input logic [7:0] d);
    ceN = e; cle = c; ale = a; ioIn = d; rdStrobe = rd; weStrobe = !rd;
    @(negedge clk);
    weStrobe = 1'b0; rdStrobe = 1'b0; cle = 1'b0; ale = 1'b0; ceN = 1'b1;
  endtask

  function automatic void modelWrite(input logic c, input logic a, input logic e, input logic [7:0] d);
    mDone = 1'b0;
    if (e) return;
    if (c && !a) begin
      mCnt = 0; mIll = 1'b0;
      if (d == 8'h00) mHalf = 1'b0;
      else if (d == 8'h01) mHalf = 1'b1;
    end else if (a && !c) begin
      case (mCnt)
        0: mCol = d;
        1: mRow[7:0] = d;
        2: begin
          mRow[14:8] = d[6:0]; mIll = d[7]; mDone = 1'b1;
          mPtr = {1'b0, mHalf, mCol};
        end
        default: ;
      endcase
      if (mCnt < 3) mCnt++;
    end
  endfunction

  task automatic doCmd(input logic [7:0] d, input string req);
    modelWrite(1, 0, 0, d); busCycle(1, 0, 0, 0, d); chkAll(req);
  endtask
  task automatic doAddr(input logic [7:0] d, input string req);
    modelWrite(0, 1, 0, d); busCycle(0, 1, 0, 0, d); chkAll(req);
  endtask
  task automatic doRead(input string req);
    mDone = 1'b0; if (mPtr != 10'd527) mPtr++;
    busCycle(0, 0, 0, 1, 8'h00); chkAll(req);
  endtask

  initial begin
    #400000;
    if (!doneFlag) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7211));
    mCol = '0; mRow = '0; mHalf = 0; mIll = 0; mDone = 0; mPtr = '0; mCnt = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chkAll("R1 reset");

    // directed: 01h then three bytes, illegal top bit
    doCmd(8'h01, "R2 cmd01");
    doAddr(8'hA5, "R3 first");
    doAddr(8'h3C, "R4 second");
    doAddr(8'hC7, "R4 R6 R7 third");
    @(negedge clk); mDone = 0; chkAll("R6 pulse ends");
    doAddr(8'h99, "R5 surplus");
    doAddr(8'h11, "R5 surplus2");
    // saturation of the pointer
    doCmd(8'h01, "R7 clear");
    doAddr(8'hFF, "R3"); doAddr(8'h00, "R4"); doAddr(8'h05, "R9 load");
    for (int i = 0; i < 20; i++) doRead("R9 saturate");
    // command mid-sequence restarts the count
    doCmd(8'h00, "R2 cmd00");
    doAddr(8'h12, "R3"); doCmd(8'h70, "R2 other code");
    doAddr(8'h34, "R8 restart"); doAddr(8'h56, "R8"); doAddr(8'h01, "R8 R9");
    // ignored bytes
    modelWrite(0, 1, 1, 8'hEE); busCycle(0, 1, 1, 0, 8'hEE); chkAll("R10 ceN high");
    modelWrite(1, 1, 0, 8'h01); busCycle(1, 1, 0, 0, 8'h01); chkAll("R10 both enables");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int op;
      logic [7:0] d;
      op = int'($urandom_range(0, 9));
      d = 8'($urandom);
      case (op)
        0: doCmd(8'($urandom_range(0, 1)), "R2 R8 rand cmd");
        1: doCmd(d, "R2 rand code");
        2, 3, 4: doAddr(d, "R3 R4 R5 R6 R7 rand addr");
        5, 6, 7: doRead("R9 rand read");
        8: begin modelWrite(0, 1, 1, d); busCycle(0, 1, 1, 0, d); chkAll("R10 rand ceN"); end
        default: begin modelWrite(1, 1, 0, d); busCycle(1, 1, 0, 0, d); chkAll("R10 rand both"); end
      endcase
    end

    doneFlag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule